// File: doc/BRIEF.md
# Compare, Conditional Move and Branch Unit

This unit executes the compare, move and control-transfer part of a small register machine's instruction set. Each cycle it takes the operation code, the current value of the destination register, the operand value, the machine's single condition flag and the current program counter. It produces the next flag, a register write request (enable plus data) and the next program counter. All results are registered, so they appear one clock after the inputs are presented.

Compares put their result only into the flag. Both unsigned and two's-complement signed orderings are supported, and equality is derived from the unsigned ordering. Moves write the operand to the destination and never change the flag. The conditional move writes only when the flag is set. Jumps change only the program counter. The jump target is the operand with its low sub-word address bits removed, so it lands on an instruction-aligned address. Every operation that does not jump, or whose condition fails, advances the PC by one.

Operation codes on `op_i`: 0 equal, 1 unsigned greater, 2 unsigned greater-or-equal, 3 signed greater, 4 signed greater-or-equal, 5 move, 6 conditional move, 7 jump, 8 jump if flag set, 9 jump if flag clear, 10 to 15 any other instruction.

Top module: `cmpbr_unit`

## Requirements
- R1: While `rst_ni` is low, `flag_o`, `reg_we_o`, `reg_wdata_o` and `pc_o` are all zero.
- R2: The outputs after a rising clock edge reflect the inputs sampled at that edge. Before the edge they still hold the previous result.
- R3: Op 0 sets the flag to 1 when `dst_i` equals `opd_i`, and to 0 otherwise.
- R4: Op 1 sets the flag to (`dst_i` > `opd_i`) and op 2 sets it to (`dst_i` >= `opd_i`), both comparing the words as unsigned.
- R5: Op 3 sets the flag to (`dst_i` > `opd_i`) and op 4 sets it to (`dst_i` >= `opd_i`), both comparing the words as two's-complement signed values.
- R6: Ops 0 to 4 leave `reg_we_o` low and set the PC to `pc_i`+1.
- R7: Op 5 raises `reg_we_o` with `reg_wdata_o` = `opd_i`, keeps the flag at `flag_i`, and sets the PC to `pc_i`+1.
- R8: Op 6 raises `reg_we_o` with `reg_wdata_o` = `opd_i` only when `flag_i` is 1. With `flag_i` at 0 it does not write, so the destination keeps its value. The flag stays `flag_i` and the PC becomes `pc_i`+1.
- R9: Op 7 loads the PC with the jump target, does not write a register, and keeps the flag.
- R10: Op 8 loads the target when `flag_i` is 1 and op 9 loads it when `flag_i` is 0. Otherwise both set the PC to `pc_i`+1. Neither writes a register or changes the flag.
- R11: Ops 10 to 15 do not write a register, keep the flag, and set the PC to `pc_i`+1. The increment wraps modulo 2^PC_W.
- R12: The jump target is `opd_i[WORD_W-1:SUB_W]`. It is zero-extended to PC_W bits when narrower than PC_W, and its low PC_W bits are taken when wider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| dst_i | input | WORD_W | Current destination register value |
| opd_i | input | WORD_W | Operand value |
| flag_i | input | 1 | Current condition flag |
| pc_i | input | PC_W | Current program counter |
| flag_o | output | 1 | Next condition flag |
| reg_we_o | output | 1 | Destination register write enable |
| reg_wdata_o | output | WORD_W | Destination register write data |
| pc_o | output | PC_W | Next program counter |

## Verification
A fault in the compare path shows up only in `flag_o`, one cycle after the offending operands. It is most likely to appear where the operands differ only in the sign bit, which is where signed and unsigned orderings disagree. A fault in the move or jump select shows up the next cycle as a spurious or missing `reg_we_o`, as a flag that changes when it should hold, or as a PC that jumps when it should step, or steps when it should jump. Because the unit holds no state beyond its output registers, every error appears in the cycle right after its inputs and never lingers. A sweep over every code, both flag values and all operand pairs of a narrow word therefore exposes it at once.

// File: rtl/cmpbr_pkg.sv
`timescale 1ns/1ps
package cmpbr_pkg;
  typedef enum logic [3:0] {
    OP_CMPE  = 4'd0,
    OP_CMPA  = 4'd1,
    OP_CMPAE = 4'd2,
    OP_CMPG  = 4'd3,
    OP_CMPGE = 4'd4,
    OP_MOV   = 4'd5,
    OP_CMOV  = 4'd6,
    OP_JMP   = 4'd7,
    OP_CJMP  = 4'd8,
    OP_CNJMP = 4'd9
  } cmpbr_op_e;
endpackage

// File: rtl/cmpbr_compare.sv
`timescale 1ns/1ps
module cmpbr_compare
  import cmpbr_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic [WORD_W-1:0] lhs_i,
  input  logic [WORD_W-1:0] rhs_i,
  input  logic [3:0]        op_i,
  output logic              is_cmp_o,
  output logic              flag_o
);
  localparam int unsigned MSB = WORD_W - 1;

  // index 0: unsigned order, index 1: signed order via sign-bit inversion
  logic [1:0] gt, ge;

  for (genvar g = 0; g < 2; g++) begin : g_order
    logic [WORD_W-1:0] l_x, r_x;
    if (g == 0) begin : g_uns
      assign l_x = lhs_i;
      assign r_x = rhs_i;
    end else begin : g_sgn
      assign l_x = {~lhs_i[MSB], lhs_i[MSB-1:0]};
      assign r_x = {~rhs_i[MSB], rhs_i[MSB-1:0]};
    end
    assign gt[g] = (l_x > r_x);
    assign ge[g] = (l_x >= r_x);
  end

  always_comb begin
    is_cmp_o = 1'b1;
    flag_o   = 1'b0;
    unique case (op_i)
      OP_CMPE:  flag_o = ge[0] & ~gt[0];
      OP_CMPA:  flag_o = gt[0];
      OP_CMPAE: flag_o = ge[0];
      OP_CMPG:  flag_o = gt[1];
      OP_CMPGE: flag_o = ge[1];
      default:  is_cmp_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cmpbr_move.sv
`timescale 1ns/1ps
module cmpbr_move
  import cmpbr_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic [3:0]        op_i,
  input  logic              flag_i,
  input  logic [WORD_W-1:0] opd_i,
  output logic              we_o,
  output logic [WORD_W-1:0] wdata_o
);
  always_comb begin
    unique case (op_i)
      OP_MOV:  we_o = 1'b1;
      OP_CMOV: we_o = flag_i;  // clear flag: no write, destination holds
      default: we_o = 1'b0;
    endcase
  end

  assign wdata_o = opd_i;
endmodule

// File: rtl/cmpbr_pc.sv
`timescale 1ns/1ps
module cmpbr_pc
  import cmpbr_pkg::*;
#(
  parameter int unsigned PC_W = 14
) (
  input  logic [3:0]      op_i,
  input  logic            flag_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic [PC_W-1:0] target_i,
  output logic [PC_W-1:0] pc_o
);
  logic            take;
  logic [PC_W-1:0] pc_inc;

  assign pc_inc = pc_i + PC_W'(1);

  always_comb begin
    unique case (op_i)
      OP_JMP:   take = 1'b1;
      OP_CJMP:  take = flag_i;
      OP_CNJMP: take = ~flag_i;
      default:  take = 1'b0;
    endcase
  end

  assign pc_o = take ? target_i : pc_inc;
endmodule

// File: rtl/cmpbr_unit.sv
`timescale 1ns/1ps
module cmpbr_unit
  import cmpbr_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned SUB_W  = 2,
  parameter int unsigned PC_W   = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        op_i,
  input  logic [WORD_W-1:0] dst_i,
  input  logic [WORD_W-1:0] opd_i,
  input  logic              flag_i,
  input  logic [PC_W-1:0]   pc_i,
  output logic              flag_o,
  output logic              reg_we_o,
  output logic [WORD_W-1:0] reg_wdata_o,
  output logic [PC_W-1:0]   pc_o
);
  localparam int unsigned TGT_W = WORD_W - SUB_W;

  logic              is_cmp, cmp_flag, we_d, flag_d;
  logic [WORD_W-1:0] wdata_d;
  logic [PC_W-1:0]   target, pc_d;

  // drop sub-word address bits, fit to PC width
  if (PC_W >= TGT_W) begin : g_tgt_ext
    assign target = PC_W'(opd_i[WORD_W-1:SUB_W]);
  end else begin : g_tgt_cut
    assign target = opd_i[SUB_W+PC_W-1:SUB_W];
  end

  cmpbr_compare #(.WORD_W(WORD_W)) u_cmp (
    .lhs_i    (dst_i),
    .rhs_i    (opd_i),
    .op_i     (op_i),
    .is_cmp_o (is_cmp),
    .flag_o   (cmp_flag)
  );

  cmpbr_move #(.WORD_W(WORD_W)) u_mov (
    .op_i    (op_i),
    .flag_i  (flag_i),
    .opd_i   (opd_i),
    .we_o    (we_d),
    .wdata_o (wdata_d)
  );

  cmpbr_pc #(.PC_W(PC_W)) u_pc (
    .op_i     (op_i),
    .flag_i   (flag_i),
    .pc_i     (pc_i),
    .target_i (target),
    .pc_o     (pc_d)
  );

  assign flag_d = is_cmp ? cmp_flag : flag_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o      <= 1'b0;
      reg_we_o    <= 1'b0;
      reg_wdata_o <= '0;
      pc_o        <= '0;
    end else begin
      flag_o      <= flag_d;
      reg_we_o    <= we_d;
      reg_wdata_o <= wdata_d;
      pc_o        <= pc_d;
    end
  end
endmodule

// File: rtl/cmpbr_unit_chk.sv
`timescale 1ns/1ps
module cmpbr_unit_chk
  import cmpbr_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned SUB_W  = 2,
  parameter int unsigned PC_W   = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [3:0]        op_i,
  input logic [WORD_W-1:0] dst_i,
  input logic [WORD_W-1:0] opd_i,
  input logic              flag_i,
  input logic [PC_W-1:0]   pc_i,
  input logic              flag_o,
  input logic              reg_we_o,
  input logic [WORD_W-1:0] reg_wdata_o,
  input logic [PC_W-1:0]   pc_o
);
  // set once a full edge has passed out of reset, so $past sees live inputs
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  p_eq_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(op_i) == OP_CMPE |-> flag_o == ($past(dst_i) == $past(opd_i)));

  p_cmp_no_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(op_i) <= 4'd4 |-> !reg_we_o && pc_o == PC_W'($past(pc_i) + 1'b1));

  p_mov_keeps_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(op_i) == OP_MOV |-> reg_we_o && reg_wdata_o == $past(opd_i)
                                        && flag_o == $past(flag_i));

  p_cmov_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(op_i) == OP_CMOV |-> reg_we_o == $past(flag_i) && flag_o == $past(flag_i));

  p_jump_no_side_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(op_i) >= OP_JMP && $past(op_i) <= OP_CNJMP |-> !reg_we_o
                                        && flag_o == $past(flag_i));

  p_cjmp_fall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(op_i) == OP_CJMP && !$past(flag_i) |-> pc_o == PC_W'($past(pc_i) + 1'b1));

  p_other_step_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(op_i) >= 4'd10 |-> !reg_we_o && flag_o == $past(flag_i)
                                      && pc_o == PC_W'($past(pc_i) + 1'b1));
endmodule

bind cmpbr_unit cmpbr_unit_chk #(.WORD_W(WORD_W), .SUB_W(SUB_W), .PC_W(PC_W)) u_chk (.*);

// File: tb/tb_cmpbr_unit.sv
`timescale 1ns/1ps
module tb_cmpbr_unit;
  localparam int W   = 5;
  localparam int SUB = 1;
  localparam int PW  = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b1;
  logic [3:0]    op_i = '0;
  logic [W-1:0]  dst_i = '0;
  logic [W-1:0]  opd_i = '0;
  logic          flag_i = 1'b0;
  logic [PW-1:0] pc_i = '0;
  logic          flag_o, reg_we_o;
  logic [W-1:0]  reg_wdata_o;
  logic [PW-1:0] pc_o;

  int checks = 0;
  int failures = 0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  cmpbr_unit #(.WORD_W(W), .SUB_W(SUB), .PC_W(PW)) dut (.*);

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s op=%0d dst=%0d opd=%0d flag=%0d pc=%0d actual=%0d expected=%0d",
               req, what, op_i, dst_i, opd_i, flag_i, pc_i, act, exp);
    end
  endtask

  initial begin
    #(20ns * 200000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1 rst_ni = 1'b0;
    op_i = 4'd5; opd_i = 5'd19; flag_i = 1'b1; pc_i = 4'd7;
    repeat (2) @(posedge clk_i);
    #5;
    // R1 reset values
    check("R1", flag_o, 0, "flag");
    check("R1", reg_we_o, 0, "we");
    check("R1", reg_wdata_o, 0, "wdata");
    check("R1", pc_o, 0, "pc");
    @(negedge clk_i) rst_ni = 1'b1;
    @(posedge clk_i); #5;
    // R2 latency: mov seen one edge later
    check("R2", reg_wdata_o, 19, "wdata");
    check("R2", pc_o, 8, "pc");
    @(negedge clk_i) opd_i = 5'd3; pc_i = 4'd2;
    #3 check("R2", reg_wdata_o, 19, "wdata before edge");

    for (int op = 0; op < 16; op++) begin
      for (int f = 0; f < 2; f++) begin
        for (int a = 0; a < 32; a++) begin
          for (int b = 0; b < 32; b++) begin
            int sa, sb, ef, ewe, epc, tgt, inc;
            string tag;
            @(negedge clk_i);
            op_i = op[3:0]; flag_i = f[0]; dst_i = a[W-1:0]; opd_i = b[W-1:0];
            pc_i = PW'(a * 3 + b + op);
            sa = (a >= 16) ? a - 32 : a;
            sb = (b >= 16) ? b - 32 : b;
            tgt = (b >> SUB) & 15;
            inc = (int'(pc_i) + 1) & 15;
            ef = f; ewe = 0; epc = inc;
            case (op)
              0: begin ef = (a == b);  tag = "R3 R6"; end
              1: begin ef = (a > b);   tag = "R4 R6"; end
              2: begin ef = (a >= b);  tag = "R4 R6"; end
              3: begin ef = (sa > sb); tag = "R5 R6"; end
              4: begin ef = (sa >= sb); tag = "R5 R6"; end
              5: begin ewe = 1;        tag = "R7"; end
              6: begin ewe = f;        tag = "R8"; end
              7: begin epc = tgt;      tag = "R9 R12"; end
              8: begin epc = f ? tgt : inc; tag = "R10 R12"; end
              9: begin epc = f ? inc : tgt; tag = "R10 R12"; end
              default: tag = "R11";
            endcase
            @(posedge clk_i); #5;
            check(tag, flag_o, ef, "flag");
            check(tag, reg_we_o, ewe, "we");
            if (ewe == 1) check(tag, reg_wdata_o, b, "wdata");
            check(tag, pc_o, epc, "pc");
          end
        end
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule